// File: doc/BRIEF.md
# Commutation-Synchronized Step-Ratio Updater

This block holds the 4-bit step ratio of the prescaler that clocks a motor commutation timer. While the timer is stopped, software loads the ratio directly. While it runs, a direct load is ignored. Software instead raises a slow-down request (ratio plus one, half-rate clock) or a speed-up request (ratio minus one, double-rate clock). The request waits for the next commutation strobe.

On every commutation strobe the block copies a bank of preload registers into their active copies and sets a commutation flag. If a request is applied on that strobe, each copied value is shifted in the matching direction. The active registers therefore keep the same time meaning under the new timer clock. Only one ratio change happens per step, and a slow-down request always goes before a speed-up request. A timer overflow raises a slow-down request by itself. One interrupt line combines the flags with per-flag mask bits.

A zero-crossing capture port loads the first active register when the motor runs in self-switched mode. It has no effect while the controller forces the steps itself (switched mode). All interfaces are plain control pins and strobes, so there is no back-pressure.

Top module: `cstep_ratio_ctrl`

## Requirements
- R1: When `run_en` is low, a `ratio_wr_en` pulse loads `ratio_wr_data` into `ratio`, visible one cycle later. While `run_en` is high, the write is ignored and `ratio` keeps its value.
- R2: While `run_en` is high, `slow_set` sets flag bit 1 (slow-down request) and `fast_set` sets flag bit 2 (speed-up request). Setting a request never changes `ratio` before a commutation strobe.
- R3: On a `comm_evt` with `run_en` high and a request pending, `ratio` steps by one: up for bit 1, down for bit 2. Each active register gets its preload value shifted right by one bit (step up) or shifted left by one bit with saturation at all-ones (step down).
- R4: The request applied at a commutation has its flag bit cleared in the same cycle that `ratio` changes.
- R5: When both requests are pending, the next commutation applies only the slow-down request and leaves bit 2 set. The commutation after that applies the speed-up request.
- R6: A slow-down request at ratio 15, or a speed-up request at ratio 0, is cleared at the commutation. The ratio does not change and the preload values are copied unshifted.
- R7: A `tmr_ovf` pulse while `run_en` is high sets flag bit 1.
- R8: Every `comm_evt` copies the preload registers (written through `pre_wr_*`, indexes 0 to NREG-1) into `act_regs` (register i at bits [i*REG_W +: REG_W]) and sets flag bit 0, one cycle after the strobe.
- R9: `irq` is high exactly when some flag bit and the same bit of `irq_mask` are both set. A flag stays set until the matching `flag_clr` bit clears it (write-1-to-clear) or, for a request, until a commutation consumes it.
- R10: While `run_en` is low, both request flags are held at zero, and `slow_set`, `fast_set` and `tmr_ovf` have no effect.
- R11: With `switched_mode` low and no commutation in that cycle, a `zc_evt` loads `zc_val` into active register 0 and leaves the others unchanged. With `switched_mode` high, `zc_evt` changes no active register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Timer running |
| ratio_wr_en | input | 1 | Direct ratio write strobe |
| ratio_wr_data | input | RATIO_W | Direct ratio value |
| slow_set | input | 1 | Set slow-down request (write-1-to-set) |
| fast_set | input | 1 | Set speed-up request (write-1-to-set) |
| comm_evt | input | 1 | Commutation strobe |
| tmr_ovf | input | 1 | Commutation timer overflow strobe |
| flag_clr | input | 3 | Write-1-to-clear for flag bits |
| irq_mask | input | 3 | Interrupt mask per flag bit |
| pre_wr_en | input | 1 | Preload register write strobe |
| pre_wr_idx | input | IDX_W | Preload register index |
| pre_wr_data | input | REG_W | Preload register value |
| switched_mode | input | 1 | Controller forces steps; captures blocked |
| zc_evt | input | 1 | Zero-crossing capture strobe |
| zc_val | input | REG_W | Captured timer value |
| ratio | output | RATIO_W | Current step ratio |
| act_regs | output | NREG*REG_W | Active timer-related registers |
| flags | output | 3 | Bit 0 commutation, bit 1 slow-down request, bit 2 speed-up request |
| irq | output | 1 | Interrupt |

## Verification
The ratio, the flags and the active registers are all registered. Each one answers a strobe at the first rising edge that samples the strobe, so its new value is due one cycle later. `irq` is combinational from the flags and the mask, so a mask change shows at once and a flag change shows in the same cycle as the flag. The bench drives every strobe for one cycle just after a falling edge and samples at the next falling edge, half a period after the edge that takes the strobe. It also checks, in the cycle where a request is set, that the ratio has not yet moved. A sweep covers every starting ratio with both request directions, including the two saturation ends.

// File: rtl/cstep_pkg.sv
package cstep_pkg;
  localparam int FLG_COMM = 0;
  localparam int FLG_SLOW = 1;
  localparam int FLG_FAST = 2;
  localparam int FLG_N    = 3;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SLOW = 2'd1,
    OP_FAST = 2'd2
  } step_op_e;
endpackage

// File: rtl/cstep_req_queue.sv
module cstep_req_queue
  import cstep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             comm_evt,
  input  logic             tmr_ovf,
  input  logic             slow_set,
  input  logic             fast_set,
  input  logic [FLG_N-1:0] flag_clr,
  output step_op_e         op,
  output logic [FLG_N-1:0] flags
);
  // Slow-down wins when both are pending; the other waits a step.
  always_comb begin
    op = OP_NONE;
    if (comm_evt && run_en) begin
      if (flags[FLG_SLOW])      op = OP_SLOW;
      else if (flags[FLG_FAST]) op = OP_FAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags[FLG_COMM] <= comm_evt | (flags[FLG_COMM] & ~flag_clr[FLG_COMM]);
      if (!run_en) begin
        flags[FLG_SLOW] <= 1'b0;
        flags[FLG_FAST] <= 1'b0;
      end else begin
        flags[FLG_SLOW] <= slow_set | tmr_ovf |
          (flags[FLG_SLOW] & ~flag_clr[FLG_SLOW] & (op != OP_SLOW));
        flags[FLG_FAST] <= fast_set |
          (flags[FLG_FAST] & ~flag_clr[FLG_FAST] & (op != OP_FAST));
      end
    end
  end
endmodule

// File: rtl/cstep_ratio_reg.sv
module cstep_ratio_reg
  import cstep_pkg::*;
#(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               wr_en,
  input  logic [RATIO_W-1:0] wr_data,
  input  step_op_e           op,
  output logic [RATIO_W-1:0] ratio,
  output logic               step_ok
);
  localparam logic [RATIO_W-1:0] R_MAX = '1;
  localparam logic [RATIO_W-1:0] R_MIN = '0;

  always_comb begin
    step_ok = ((op == OP_SLOW) && (ratio != R_MAX)) ||
              ((op == OP_FAST) && (ratio != R_MIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio <= '0;
    end else if (!run_en && wr_en) begin
      ratio <= wr_data;
    end else if (step_ok) begin
      if (op == OP_SLOW) ratio <= ratio + 1'b1;
      else               ratio <= ratio - 1'b1;
    end
  end
endmodule

// File: rtl/cstep_shift_bank.sv
module cstep_shift_bank
  import cstep_pkg::*;
#(
  parameter int NREG  = 3,
  parameter int REG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pre_wr_en,
  input  logic [IDX_W-1:0]      pre_wr_idx,
  input  logic [REG_W-1:0]      pre_wr_data,
  input  logic                  comm_evt,
  input  step_op_e              op,
  input  logic                  step_ok,
  input  logic                  switched_mode,
  input  logic                  zc_evt,
  input  logic [REG_W-1:0]      zc_val,
  output logic [NREG*REG_W-1:0] act_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [REG_W-1:0] pre_q;
    logic [REG_W-1:0] act_q;
    logic [REG_W-1:0] scaled;

    always_comb begin
      scaled = pre_q;
      if (step_ok && op == OP_SLOW)
        scaled = pre_q >> 1;
      else if (step_ok && op == OP_FAST)
        scaled = pre_q[REG_W-1] ? '1 : (pre_q << 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else if (pre_wr_en && pre_wr_idx == IDX_W'(g)) pre_q <= pre_wr_data;
    end

    if (g == 0) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        act_q <= '0;
        else if (comm_evt)                 act_q <= scaled;
        else if (zc_evt && !switched_mode) act_q <= zc_val;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        act_q <= '0;
        else if (comm_evt) act_q <= scaled;
      end
    end

    assign act_flat[g*REG_W +: REG_W] = act_q;
  end
endmodule

// File: rtl/cstep_ratio_ctrl.sv
module cstep_ratio_ctrl
  import cstep_pkg::*;
#(
  parameter int RATIO_W = 4,
  parameter int NREG    = 3,
  parameter int REG_W   = 8,
  localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_en,
  input  logic                  ratio_wr_en,
  input  logic [RATIO_W-1:0]    ratio_wr_data,
  input  logic                  slow_set,
  input  logic                  fast_set,
  input  logic                  comm_evt,
  input  logic                  tmr_ovf,
  input  logic [2:0]            flag_clr,
  input  logic [2:0]            irq_mask,
  input  logic                  pre_wr_en,
  input  logic [IDX_W-1:0]      pre_wr_idx,
  input  logic [REG_W-1:0]      pre_wr_data,
  input  logic                  switched_mode,
  input  logic                  zc_evt,
  input  logic [REG_W-1:0]      zc_val,
  output logic [RATIO_W-1:0]    ratio,
  output logic [NREG*REG_W-1:0] act_regs,
  output logic [2:0]            flags,
  output logic                  irq
);
  step_op_e op;
  logic     step_ok;

  cstep_req_queue u_queue (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .comm_evt(comm_evt),
    .tmr_ovf(tmr_ovf), .slow_set(slow_set), .fast_set(fast_set),
    .flag_clr(flag_clr), .op(op), .flags(flags)
  );

  cstep_ratio_reg #(.RATIO_W(RATIO_W)) u_ratio (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(ratio_wr_en),
    .wr_data(ratio_wr_data), .op(op), .ratio(ratio), .step_ok(step_ok)
  );

  cstep_shift_bank #(.NREG(NREG), .REG_W(REG_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .pre_wr_en(pre_wr_en), .pre_wr_idx(pre_wr_idx),
    .pre_wr_data(pre_wr_data), .comm_evt(comm_evt), .op(op),
    .step_ok(step_ok), .switched_mode(switched_mode), .zc_evt(zc_evt),
    .zc_val(zc_val), .act_flat(act_regs)
  );

  assign irq = |(flags & irq_mask);
endmodule

// File: rtl/cstep_ratio_ctrl_chk.sv
module cstep_ratio_ctrl_chk #(
  parameter int RATIO_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_en,
  input logic               ratio_wr_en,
  input logic [RATIO_W-1:0] ratio_wr_data,
  input logic               comm_evt,
  input logic [2:0]         flag_clr,
  input logic [RATIO_W-1:0] ratio,
  input logic [2:0]         flags
);
  p_direct_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && ratio_wr_en) |=> (ratio == $past(ratio_wr_data)));

  p_hold_until_comm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !comm_evt) |=> $stable(ratio));

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && comm_evt) |=> ((ratio == $past(ratio)) ||
      (ratio == RATIO_W'($past(ratio) + 1'b1)) ||
      (ratio == RATIO_W'($past(ratio) - 1'b1))));

  p_slow_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && comm_evt && flags[1] && flags[2] && !flag_clr[2] &&
     (ratio != '1)) |=> ((ratio == RATIO_W'($past(ratio) + 1'b1)) && flags[2]));

  p_comm_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    comm_evt |=> flags[0]);

  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (flags[2:1] == 2'b00));
endmodule

bind cstep_ratio_ctrl cstep_ratio_ctrl_chk #(.RATIO_W(RATIO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .ratio_wr_en(ratio_wr_en),
  .ratio_wr_data(ratio_wr_data), .comm_evt(comm_evt), .flag_clr(flag_clr),
  .ratio(ratio), .flags(flags)
);

// File: tb/cstep_ratio_ctrl_tb_top.sv
module cstep_ratio_ctrl_tb_top;
  localparam int RW = 4;
  localparam int NR = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 0, ratio_wr_en = 0, slow_set = 0, fast_set = 0;
  logic comm_evt = 0, tmr_ovf = 0, pre_wr_en = 0, switched_mode = 0, zc_evt = 0;
  logic [RW-1:0] ratio_wr_data = '0;
  logic [2:0] flag_clr = '0, irq_mask = '0;
  logic [1:0] pre_wr_idx = '0;
  logic [DW-1:0] pre_wr_data = '0, zc_val = '0;
  logic [RW-1:0] ratio;
  logic [NR*DW-1:0] act_regs;
  logic [2:0] flags;
  logic irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cstep_ratio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ratio_wr_en(ratio_wr_en),
    .ratio_wr_data(ratio_wr_data), .slow_set(slow_set), .fast_set(fast_set),
    .comm_evt(comm_evt), .tmr_ovf(tmr_ovf), .flag_clr(flag_clr),
    .irq_mask(irq_mask), .pre_wr_en(pre_wr_en), .pre_wr_idx(pre_wr_idx),
    .pre_wr_data(pre_wr_data), .switched_mode(switched_mode), .zc_evt(zc_evt),
    .zc_val(zc_val), .ratio(ratio), .act_regs(act_regs), .flags(flags), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs change right after a falling edge; one tick spans the next
  // rising edge and ends at the following falling edge.
  task automatic tick();
    @(negedge clk);
    ratio_wr_en = 0; slow_set = 0; fast_set = 0; comm_evt = 0; tmr_ovf = 0;
    pre_wr_en = 0; zc_evt = 0; flag_clr = '0;
  endtask

  function automatic int reg_of(int i);
    return int'(act_regs[i*DW +: DW]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int pre [NR];
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset ratio", int'(ratio), 0);
    chk("reset flags", int'(flags), 0);
    chk("reset act_regs", int'(act_regs), 0);

    // Sweep: every start ratio, both request directions (R3, R4, R6, R8).
    for (int r = 0; r < 16; r++) begin
      for (int d = 0; d < 2; d++) begin
        int exp_r;
        run_en = 0;
        ratio_wr_en = 1; ratio_wr_data = RW'(r); tick();
        chk("R1 direct load", int'(ratio), r);
        for (int i = 0; i < NR; i++) begin
          pre[i] = (r * 37 + i * 91 + d * 53 + 11) % 256;
          pre_wr_en = 1; pre_wr_idx = 2'(i); pre_wr_data = DW'(pre[i]); tick();
        end
        run_en = 1; tick();
        if (d == 0) slow_set = 1; else fast_set = 1;
        tick();
        chk("R2 request pending", int'(flags[d == 0 ? 1 : 2]), 1);
        chk("R2 ratio held", int'(ratio), r);
        comm_evt = 1; tick();
        if (d == 0) exp_r = (r == 15) ? 15 : r + 1;
        else        exp_r = (r == 0) ? 0 : r - 1;
        chk((exp_r == r) ? "R6 saturated ratio" : "R3 ratio step", int'(ratio), exp_r);
        chk("R4 request consumed", int'(flags[2:1]), 0);
        chk("R8 comm flag", int'(flags[0]), 1);
        for (int i = 0; i < NR; i++) begin
          int e;
          if (exp_r == r)  e = pre[i];
          else if (d == 0) e = pre[i] / 2;
          else             e = (pre[i] * 2 > 255) ? 255 : pre[i] * 2;
          chk((exp_r == r) ? "R6 unshifted copy" : "R3 rescaled reg", reg_of(i), e);
        end
        flag_clr = 3'b001; tick();
        chk("R9 comm flag cleared", int'(flags[0]), 0);
        run_en = 0; tick();
      end
    end

    // R1: write while running is ignored.
    ratio_wr_en = 1; ratio_wr_data = 4'd5; tick();
    run_en = 1; tick();
    ratio_wr_en = 1; ratio_wr_data = 4'd9; tick();
    chk("R1 write ignored while running", int'(ratio), 5);

    // R5: both pending, slow-down first then speed-up.
    slow_set = 1; fast_set = 1; tick();
    chk("R5 both pending", int'(flags[2:1]), 3);
    comm_evt = 1; tick();
    chk("R5 first comm ratio", int'(ratio), 6);
    chk("R5 speed-up still pending", int'(flags[2:1]), 2);
    comm_evt = 1; tick();
    chk("R5 second comm ratio", int'(ratio), 5);
    chk("R5 all consumed", int'(flags[2:1]), 0);

    // R7: overflow sets slow-down request; R9 interrupt masking.
    flag_clr = 3'b001; tick();
    tmr_ovf = 1; tick();
    chk("R7 overflow request", int'(flags[1]), 1);
    irq_mask = 3'b001; #1;
    chk("R9 irq masked off", int'(irq), 0);
    irq_mask = 3'b010; #1;
    chk("R9 irq from overflow", int'(irq), 1);
    tick(); tick();
    chk("R9 flag persists", int'(flags[1]), 1);
    flag_clr = 3'b010; tick();
    chk("R9 software clear", int'(flags[1]), 0);
    chk("R9 irq drops", int'(irq), 0);
    irq_mask = '0;

    // R10: stopping clears requests; sets while stopped have no effect.
    fast_set = 1; tick();
    run_en = 0; tick();
    chk("R10 cleared on stop", int'(flags[2:1]), 0);
    fast_set = 1; slow_set = 1; tmr_ovf = 1; tick();
    chk("R10 set ignored while stopped", int'(flags[2:1]), 0);
    chk("R10 ratio unchanged", int'(ratio), 5);

    // R11: zero-crossing capture.
    begin
      int r1, r2;
      r1 = reg_of(1); r2 = reg_of(2);
      switched_mode = 0; zc_evt = 1; zc_val = 8'h3C; tick();
      chk("R11 capture loads reg0", reg_of(0), 'h3C);
      chk("R11 reg1 untouched", reg_of(1), r1);
      chk("R11 reg2 untouched", reg_of(2), r2);
      switched_mode = 1; zc_evt = 1; zc_val = 8'hA5; tick();
      chk("R11 switched mode blocks capture", reg_of(0), 'h3C);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule